// File: doc/BRIEF.md
# Irregular Transition Resolver with Row Register File

This block sits next to the regular add-compare datapath of a left-to-right trellis scorer. Some states have predecessors more than two positions back, always inside the same phoneme model. The block handles the extra candidates of such a state. It keeps the previous-frame metrics of the current phoneme's leading states in a small dual-port register file. The write row comes from a one-hot shift register, which is restarted whenever a fetched state carries the phoneme-start tag. No write address decoder is used.

A separate stream supplies the irregular transition entries. Each entry holds an 8-bit transition metric, a predecessor index and a "more entries follow" flag. The predecessor index addresses the register file directly. When a fetched state is marked irregular, the block adds the first entry's metric to the stored predecessor metric and keeps the larger of that sum and the regular result. If more entries follow, the block stalls the regular datapath and consumes one entry per cycle. The final metric leaves one cycle after the last entry.

Larger metrics are better. The tag of each state comes in already decoded. Address counters for the external memories lie outside this block.

Top module: `irr_resolver`

## Requirements
- R1: After reset, `stall_reg`, `out_valid` and `irr_inc` are low with idle inputs. Every row of the register file reads as empty, so an irregular candidate taken from it loses the compare.
- R2: An accepted fetch with `tag_irreg`=0 gives `out_valid`=1 on the next cycle, with `out_metric` equal to that fetch's `reg_result`.
- R3: An accepted fetch with `tag_phon_start`=1 writes `fetch_metric` into row 0. Each later accepted fetch writes the next higher row. Fetches beyond the last row (depth = `MAX_STATES`-3), and fetches made before any phoneme start, write nothing.
- R4: An accepted fetch with `tag_irreg`=1 and `irr_cont`=0 drives `irr_inc` high in that cycle and raises no stall. On the next cycle `out_metric` = max(`reg_result`, row[`irr_pred`] + `irr_metric`).
- R5: If `irr_cont`=1 on the irregular fetch, `stall_reg` goes high from the next cycle on, and one entry is consumed per stalled cycle, with `irr_inc` high. The stall ends the cycle after an entry with `irr_cont`=0 is consumed. `out_valid` then rises, with the maximum over the regular result and all candidates.
- R6: Fetch inputs (`fetch_valid`, tags, `fetch_metric`, `reg_result`) presented while `stall_reg` is high are ignored. They write no row, restart no pointer and do not enter the compare.
- R7: When a read and a write address the same row in one cycle, the read returns the row's previous content.
- R8: A fetch with `tag_nan`=1 marks its row empty without storing its metric. A later read of that row loses every compare.
- R9: The candidate sum saturates at 2^`MET_W`-1.
- R10: A predecessor index at or beyond the file depth reads as empty.
- R11: `irr_inc` stays low in cycles with no accepted irregular fetch and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A state metric is fetched this cycle |
| fetch_metric | input | MET_W | Previous-frame metric of the fetched state |
| tag_nan | input | 1 | Fetched state holds no number |
| tag_phon_start | input | 1 | Fetched state starts a phoneme model |
| tag_irreg | input | 1 | Fetched state has irregular predecessors |
| reg_result | input | MET_W | Result of the regular add-compare for this state |
| irr_metric | input | TM_W | Transition metric of the current irregular entry |
| irr_cont | input | 1 | Another irregular entry follows for this state |
| irr_pred | input | IDX_W | Predecessor index (register file row) of the entry |
| irr_inc | output | 1 | Advance the irregular entry counter |
| stall_reg | output | 1 | Hold the regular datapath |
| out_valid | output | 1 | Updated state metric available |
| out_metric | output | MET_W | Updated state metric |

## Verification
The bench fills a phoneme's rows, then walks a table of single irregular lookups. The table covers ties, a regular result that beats the candidate, and an index past the last row. A design that wrapped the index or stored rows out of order would give wrong maxima here. A three-entry chain is run with a phoneme-start fetch and a large regular result held on the inputs during the stall. A design that let stalled fetches through would restart the row pointer, or report that large value, and a design with an off-by-one release would pulse the output early. Directed cases then cover a same-cycle read and write of one row, a not-a-number fetch over a valid row, and a sum that overflows. These expose a read that sees the new data, a stale metric winning, or a wrapped sum.

// File: rtl/irr_pkg.sv
package irr_pkg;

    // Default widths shared by the resolver and its sub-blocks.
    localparam int unsigned DEF_MET_W      = 16;
    localparam int unsigned DEF_TM_W       = 8;
    localparam int unsigned DEF_MAX_STATES = 8;

    // Decoded tag bundle of a fetched state.
    typedef struct packed {
        logic nan;
        logic phon_start;
        logic irreg;
    } state_tag_t;

    // Phase of the irregular chain controller.
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_CHAIN = 1'b1
    } seq_state_e;

endpackage

// File: rtl/irr_row_pointer.sv
module irr_row_pointer #(
    parameter int DEPTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             phon_start,
    output logic [DEPTH-1:0] row_lines
);
    localparam logic [DEPTH-1:0] HEAD = {1'b1, {(DEPTH-1){1'b0}}};

    // Shift register: leftmost stage is row 0.
    logic [DEPTH-1:0] ptr_q;
    logic [DEPTH-1:0] ptr_next;

    always_comb begin
        if (phon_start) ptr_next = HEAD;
        else            ptr_next = ptr_q >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst)       ptr_q <= '0;
        else if (step) ptr_q <= ptr_next;
    end

    // Map shift-register stages onto row-ordered word lines.
    for (genvar k = 0; k < DEPTH; k++) begin : g_lines
        assign row_lines[k] = step & ptr_next[DEPTH-1-k];
    end

    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ptr_q)); // R3

    AST_START_ROW0: assert property (@(posedge clk) disable iff (rst)
        (step && phon_start) |=> ptr_q == HEAD); // R3

endmodule

// File: rtl/irr_regfile.sv
module irr_regfile #(
    parameter int DEPTH = 5,
    parameter int MET_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] row_lines,
    input  logic [MET_W-1:0] wr_metric,
    input  logic             wr_number,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [MET_W-1:0] rd_metric,
    output logic             rd_full
);
    logic [DEPTH-1:0]            full_q;
    logic [DEPTH-1:0][MET_W-1:0] metric_q;

    // Write port: a row updates only when its word line is high.
    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (row_lines[k]) begin
                    full_q[k] <= wr_number;
                    if (wr_number) metric_q[k] <= wr_metric;
                end
            end
        end
    end

    // Read port: asynchronous, sees the contents before this edge.
    always_comb begin
        rd_metric = '0;
        rd_full   = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_metric = metric_q[k];
                rd_full   = full_q[k];
            end
        end
    end

    AST_WL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_lines)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (row_lines == '0) |=> $stable(full_q)); // R6

endmodule

// File: rtl/irr_chain_ctrl.sv
module irr_chain_ctrl
    import irr_pkg::*;
#(
    parameter int MET_W = 16,
    parameter int TM_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_irreg,
    input  logic             accept_reg,
    input  logic [MET_W-1:0] reg_result,
    input  logic [TM_W-1:0]  irr_metric,
    input  logic             irr_cont,
    input  logic [MET_W-1:0] rd_metric,
    input  logic             rd_full,
    output logic             busy,
    output logic             irr_inc,
    output logic             out_valid,
    output logic [MET_W-1:0] out_metric
);
    localparam logic [MET_W-1:0] SAT_MAX = '1;

    seq_state_e       seq_q;
    logic [MET_W-1:0] acc_q;
    logic [MET_W:0]   raw_sum;
    logic [MET_W-1:0] cand;
    logic [MET_W-1:0] base;
    logic [MET_W-1:0] best;

    assign busy    = (seq_q == SEQ_CHAIN);
    assign irr_inc = busy | accept_irreg;

    // Saturating add of stored predecessor and transition metric.
    always_comb begin
        raw_sum = {1'b0, rd_metric} + (MET_W+1)'(irr_metric);
        cand    = raw_sum[MET_W] ? SAT_MAX : raw_sum[MET_W-1:0];
        base    = busy ? acc_q : reg_result;
        best    = (rd_full && cand > base) ? cand : base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q      <= SEQ_IDLE;
            acc_q      <= '0;
            out_valid  <= 1'b0;
            out_metric <= '0;
        end else begin
            out_valid <= 1'b0;
            if (busy) begin
                acc_q <= best;
                if (!irr_cont) begin
                    seq_q      <= SEQ_IDLE;
                    out_valid  <= 1'b1;
                    out_metric <= best;
                end
            end else if (accept_irreg) begin
                if (irr_cont) begin
                    seq_q <= SEQ_CHAIN;
                    acc_q <= best;
                end else begin
                    out_valid  <= 1'b1;
                    out_metric <= best;
                end
            end else if (accept_reg) begin
                out_valid  <= 1'b1;
                out_metric <= reg_result;
            end
        end
    end

    AST_STALL_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        busy |-> irr_inc); // R5

    AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (busy && !irr_cont) |=> (out_valid && !busy)); // R5

    AST_NO_OUT_IN_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (accept_irreg && irr_cont) |=> (busy && !out_valid)); // R5

    AST_REG_PASS: assert property (@(posedge clk) disable iff (rst)
        accept_reg |=> (out_valid && out_metric == $past(reg_result))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cand >= rd_metric); // R9

endmodule

// File: rtl/irr_resolver.sv
module irr_resolver
    import irr_pkg::*;
#(
    parameter int MET_W      = DEF_MET_W,
    parameter int TM_W       = DEF_TM_W,
    parameter int MAX_STATES = DEF_MAX_STATES,
    parameter int IDX_W      = $clog2(MAX_STATES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic [MET_W-1:0] fetch_metric,
    input  logic             tag_nan,
    input  logic             tag_phon_start,
    input  logic             tag_irreg,
    input  logic [MET_W-1:0] reg_result,
    input  logic [TM_W-1:0]  irr_metric,
    input  logic             irr_cont,
    input  logic [IDX_W-1:0] irr_pred,
    output logic             irr_inc,
    output logic             stall_reg,
    output logic             out_valid,
    output logic [MET_W-1:0] out_metric
);
    localparam int DEPTH = MAX_STATES - 3;

    state_tag_t       tag;
    logic             busy;
    logic             accept;
    logic [DEPTH-1:0] row_lines;
    logic [MET_W-1:0] rd_metric;
    logic             rd_full;

    assign tag       = '{nan: tag_nan, phon_start: tag_phon_start, irreg: tag_irreg};
    assign accept    = fetch_valid & ~busy;
    assign stall_reg = busy;

    irr_row_pointer #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .step       (accept),
        .phon_start (tag.phon_start),
        .row_lines  (row_lines)
    );

    irr_regfile #(.DEPTH(DEPTH), .MET_W(MET_W), .IDX_W(IDX_W)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .row_lines (row_lines),
        .wr_metric (fetch_metric),
        .wr_number (~tag.nan),
        .rd_idx    (irr_pred),
        .rd_metric (rd_metric),
        .rd_full   (rd_full)
    );

    irr_chain_ctrl #(.MET_W(MET_W), .TM_W(TM_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .accept_irreg (accept & tag.irreg),
        .accept_reg   (accept & ~tag.irreg),
        .reg_result   (reg_result),
        .irr_metric   (irr_metric),
        .irr_cont     (irr_cont),
        .rd_metric    (rd_metric),
        .rd_full      (rd_full),
        .busy         (busy),
        .irr_inc      (irr_inc),
        .out_valid    (out_valid),
        .out_metric   (out_metric)
    );

    AST_STALL_BLOCKS_ROWS: assert property (@(posedge clk) disable iff (rst)
        stall_reg |-> (row_lines == '0)); // R6

    AST_IDLE_NO_INC: assert property (@(posedge clk) disable iff (rst)
        (!stall_reg && !(fetch_valid && tag_irreg)) |-> !irr_inc); // R11

endmodule

// File: tb/irr_resolver_tb.sv
module irr_resolver_tb_top;
    localparam int MET_W = 16;
    localparam int TM_W  = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             fetch_valid;
    logic [MET_W-1:0] fetch_metric;
    logic             tag_nan, tag_phon_start, tag_irreg;
    logic [MET_W-1:0] reg_result;
    logic [TM_W-1:0]  irr_metric;
    logic             irr_cont;
    logic [IDX_W-1:0] irr_pred;
    logic             irr_inc, stall_reg, out_valid;
    logic [MET_W-1:0] out_metric;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irr_resolver dut_i (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_metric(fetch_metric),
        .tag_nan(tag_nan), .tag_phon_start(tag_phon_start), .tag_irreg(tag_irreg),
        .reg_result(reg_result), .irr_metric(irr_metric), .irr_cont(irr_cont),
        .irr_pred(irr_pred), .irr_inc(irr_inc), .stall_reg(stall_reg),
        .out_valid(out_valid), .out_metric(out_metric)
    );

    // pred(8) trans(8) regular(16) expected(16); rows hold 100,200,300,400,500
    localparam logic [47:0] VEC_TAB [0:5] = '{
        {8'd0, 8'd10,  16'd50,   16'd110 },
        {8'd2, 8'd5,   16'd400,  16'd400 },
        {8'd4, 8'd255, 16'd0,    16'd755 },
        {8'd1, 8'd0,   16'd200,  16'd200 },
        {8'd3, 8'd20,  16'd1000, 16'd1000},
        {8'd6, 8'd255, 16'd7,    16'd7   }
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        fetch_valid = 0; fetch_metric = '0; tag_nan = 0; tag_phon_start = 0;
        tag_irreg = 0; reg_result = '0; irr_metric = '0; irr_cont = 0; irr_pred = '0;
    endtask

    // One accepted fetch; checks irr_inc in-cycle and the result one cycle later.
    task automatic fetch1(input string req, input logic [15:0] met, input logic nan,
                          input logic ps, input logic irr, input logic [15:0] rr,
                          input logic [7:0] tm, input logic [2:0] pred,
                          input logic [15:0] exp);
        @(negedge clk);
        fetch_valid = 1; fetch_metric = met; tag_nan = nan; tag_phon_start = ps;
        tag_irreg = irr; reg_result = rr; irr_metric = tm; irr_cont = 0; irr_pred = pred;
        #1 chk({req, " irr_inc"}, 32'(irr_inc), 32'(irr));
        chk({req, " no stall"}, 32'(stall_reg), 0);
        @(negedge clk);
        idle();
        chk({req, " out_valid"}, 32'(out_valid), 1);
        chk({req, " out_metric"}, 32'(out_metric), 32'(exp));
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R1 stall after reset", 32'(stall_reg), 0);
        chk("R1 out_valid after reset", 32'(out_valid), 0);
        chk("R11 irr_inc idle", 32'(irr_inc), 0);
        // R1 / R3: empty row, no phoneme start yet, so nothing was written
        fetch1("R1 empty row loses", 16'd900, 0, 0, 1, 16'd3, 8'd50, 3'd0, 16'd3);

        // R3 / R2: fill rows 0..4, regular pass-through
        fetch1("R2 regular r3_row0", 16'd100, 0, 1, 0, 16'd11, 8'd0, 3'd0, 16'd11);
        for (int k = 1; k < 5; k++)
            fetch1("R2 regular R3 fill", 16'(100 * (k + 1)), 0, 0, 0, 16'(k + 20),
                   8'd0, 3'd0, 16'(k + 20));

        // R4 / R10 table: pointer now shifted out, these fetches write nothing (R3)
        for (int i = 0; i < 6; i++)
            fetch1("R4 R10 table", 16'd9, 0, 0, 1, VEC_TAB[i][31:16], VEC_TAB[i][39:32],
                   VEC_TAB[i][42:40], VEC_TAB[i][15:0]);

        // R5 / R6: three-entry chain, stalled fetch inputs must be ignored
        @(negedge clk);
        fetch_valid = 1; fetch_metric = 16'd0; tag_irreg = 1; reg_result = 16'd10;
        irr_pred = 3'd0; irr_metric = 8'd1; irr_cont = 1;
        #1 chk("R5 first entry irr_inc", 32'(irr_inc), 1);
        @(negedge clk);
        chk("R5 stall raised", 32'(stall_reg), 1);
        chk("R5 no early out", 32'(out_valid), 0);
        tag_irreg = 0; tag_phon_start = 1; fetch_metric = 16'd7; reg_result = 16'd9999;
        irr_pred = 3'd2; irr_metric = 8'd50; irr_cont = 1;
        #1 chk("R5 stalled irr_inc", 32'(irr_inc), 1);
        @(negedge clk);
        chk("R5 stall held", 32'(stall_reg), 1);
        chk("R5 no out mid-chain", 32'(out_valid), 0);
        irr_pred = 3'd4; irr_metric = 8'd3; irr_cont = 0;
        @(negedge clk);
        idle();
        chk("R5 out_valid after last", 32'(out_valid), 1);
        chk("R5 R6 chain best", 32'(out_metric), 503);
        chk("R5 stall released", 32'(stall_reg), 0);
        fetch1("R6 row0 untouched by stalled fetch", 16'd9, 0, 0, 1, 16'd0, 8'd0, 3'd0,
               16'd100);

        // R7: same-cycle read and write of row 1
        fetch1("R7 new phoneme", 16'd1000, 0, 1, 0, 16'd1, 8'd0, 3'd0, 16'd1);
        fetch1("R7 read old value", 16'd2000, 0, 0, 1, 16'd0, 8'd0, 3'd1, 16'd200);
        fetch1("R7 new value later", 16'd5, 0, 0, 1, 16'd0, 8'd0, 3'd1, 16'd2000);

        // R8: not-a-number fetch empties row 3 (held 400 before)
        fetch1("R8 nan fetch", 16'd60000, 1, 0, 0, 16'd4, 8'd0, 3'd0, 16'd4);
        fetch1("R8 nan row loses", 16'd9, 0, 0, 1, 16'd1, 8'd0, 3'd3, 16'd1);

        // R9: saturation
        fetch1("R9 phoneme", 16'd65500, 0, 1, 0, 16'd0, 8'd0, 3'd0, 16'd0);
        fetch1("R9 saturated sum", 16'd9, 0, 0, 1, 16'd0, 8'd100, 3'd0, 16'd65535);

        @(negedge clk);
        chk("R11 irr_inc idle at end", 32'(irr_inc), 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule